// File: doc/BRIEF.md
# Over-Temperature Alert Generator

The block compares two digital temperature readings, one from a system sensor and one from a CPU sensor, against a programmable upper limit and a lower hysteresis threshold. Its result goes out on a single shared active-low pin. Each sensor keeps a one-bit over-limit flag. The flag sets when the reading rises strictly above the limit and clears when the reading drops strictly below the hysteresis threshold. Both alert modes are built from these flags.

In comparator mode the pin follows the flags of the enabled sensors. In interrupt mode, every change of a flag is latched as an event. The event holds the pin low until a one-cycle status-read strobe clears it. A pin-select input can hand the pin over to an externally generated system-management interrupt. Changing the mode input clears all latched events.

Top module: `ota_alert_gen`

## Requirements
- R1: With `pin_sel_smi` = 1, `alert_n` equals `smi_n` in the same cycle. With `pin_sel_smi` = 0, `alert_n` carries the over-temperature alert.
- R2: A sensor whose enable input is 0 never pulls `alert_n` low. Flag changes that happen while a sensor is disabled are never latched as events.
- R3: The alert is active low: `alert_n` = 0 means asserted. After reset, with `pin_sel_smi` = 0, `alert_n` is 1.
- R4: Readings, limit and threshold are signed two's-complement values. A reading strictly greater than the limit sets that sensor's flag on the next clock edge. This takes priority over R5.
- R5: A reading strictly less than the hysteresis threshold, and not above the limit, clears the flag on the next clock edge. A reading that lies between the two thresholds, or equals either of them, leaves the flag unchanged.
- R6: With `mode_intr` = 0 (comparator mode), `alert_n` is 0 exactly while at least one enabled sensor has its flag set.
- R7: With `mode_intr` = 1 (interrupt mode), each flag transition of an enabled sensor latches an event. The transitions are a rise above the limit and a drop below the threshold. No further event occurs while the reading stays above the limit. `alert_n` is 0 while any enabled sensor holds a latched event.
- R8: A latched event persists until a cycle with `stat_rd` = 1, which clears the latched events of both sensors. An event that occurs in the same cycle as the strobe stays latched.
- R9: A cycle in which `mode_intr` differs from its value in the previous cycle clears all latched events. An event that occurs in that same cycle stays latched.
- R10: A synchronous reset clears both flags, both latched events and the stored mode. The stored mode returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| temp_sys | input | TW | System sensor reading, signed |
| temp_cpu | input | TW | CPU sensor reading, signed |
| lim_hi | input | TW | Over-temperature limit, signed |
| lim_hyst | input | TW | Hysteresis threshold, signed |
| mode_intr | input | 1 | 0 = comparator mode, 1 = interrupt mode |
| en_sys | input | 1 | Enable for the system sensor |
| en_cpu | input | 1 | Enable for the CPU sensor |
| pin_sel_smi | input | 1 | 1 = pin carries smi_n, 0 = pin carries the over-temperature alert |
| smi_n | input | 1 | External system-management interrupt, active low |
| stat_rd | input | 1 | One-cycle status-read strobe that clears latched events |
| alert_n | output | 1 | Shared active-low output pin |

## Verification
Each sensor's reading is swept in single steps across the full signed range, upward and then downward. This is done in both modes and with every combination of enables. Readings equal to the limit and the threshold separate strict comparisons from inclusive ones. Readings between the two thresholds separate hysteresis from a plain threshold compare. The two extreme settings (maximum limit, minimum threshold) show that no flag can change there.

In interrupt mode the status-read strobe is issued at intervals that do not divide the sweep length, so clears land both on crossing cycles and away from them. This tells event-wins-over-clear apart from clear-wins. It also shows the difference between latching and following the flag. Separate directed sequences toggle the mode with an event pending and toggle `smi_n` under both pin selections.

// File: rtl/ota_pkg.sv
package ota_pkg;

    // Per-sensor state: over-limit flag and latched event.
    typedef struct packed {
        logic flag;
        logic evt;
    } ota_sens_t;

    localparam int unsigned OTA_NSENS = 2;
    localparam int unsigned OTA_IDX_SYS = 0;
    localparam int unsigned OTA_IDX_CPU = 1;

endpackage

// File: rtl/ota_temp_cmp.sv
module ota_temp_cmp #(
    parameter int unsigned TW = 8
) (
    input  logic [TW-1:0] temp,
    input  logic [TW-1:0] lim_hi,
    input  logic [TW-1:0] lim_hyst,
    output logic          above,
    output logic          below
);
    always_comb begin
        above = $signed(temp) > $signed(lim_hi);
        below = $signed(temp) < $signed(lim_hyst);
    end
endmodule

// File: rtl/ota_sensor_track.sv
module ota_sensor_track
    import ota_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic above,
    input  logic below,
    input  logic en,
    input  logic clr,
    output logic flag,
    output logic evt
);
    ota_sens_t st_d, st_q;
    logic      chg;

    always_comb begin
        st_d = st_q;
        if (above) begin
            st_d.flag = 1'b1;
        end else if (below) begin
            st_d.flag = 1'b0;
        end
        chg = st_d.flag != st_q.flag;
        if (chg && en) begin
            st_d.evt = 1'b1;          // a new event beats a clear
        end else if (clr) begin
            st_d.evt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign evt  = st_q.evt;
endmodule

// File: rtl/ota_pin_mux.sv
module ota_pin_mux (
    input  logic ot_any,
    input  logic pin_sel_smi,
    input  logic smi_n,
    output logic alert_n
);
    always_comb begin
        if (pin_sel_smi) begin
            alert_n = smi_n;
        end else begin
            alert_n = ~ot_any;
        end
    end
endmodule

// File: rtl/ota_alert_gen.sv
module ota_alert_gen
    import ota_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] temp_sys,
    input  logic [TW-1:0] temp_cpu,
    input  logic [TW-1:0] lim_hi,
    input  logic [TW-1:0] lim_hyst,
    input  logic          mode_intr,
    input  logic          en_sys,
    input  logic          en_cpu,
    input  logic          pin_sel_smi,
    input  logic          smi_n,
    input  logic          stat_rd,
    output logic          alert_n
);
    localparam int unsigned NS = OTA_NSENS;

    logic [TW-1:0] temp_v [NS];
    logic [NS-1:0] en_v;
    logic [NS-1:0] above_v, below_v;
    logic [NS-1:0] flag_q, evt_q;
    logic          mode_d, mode_q;
    logic          clr;
    logic          ot_any;

    always_comb begin
        temp_v[OTA_IDX_SYS] = temp_sys;
        temp_v[OTA_IDX_CPU] = temp_cpu;
        en_v[OTA_IDX_SYS]   = en_sys;
        en_v[OTA_IDX_CPU]   = en_cpu;
    end

    // Stored mode, used to detect a mode change.
    always_comb begin
        mode_d = mode_intr;
        clr    = stat_rd | (mode_intr != mode_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
        end
    end

    for (genvar i = 0; i < NS; i++) begin : g_sens
        ota_temp_cmp #(.TW(TW)) u_cmp (
            .temp     (temp_v[i]),
            .lim_hi   (lim_hi),
            .lim_hyst (lim_hyst),
            .above    (above_v[i]),
            .below    (below_v[i])
        );
        ota_sensor_track u_trk (
            .clk   (clk),
            .rst   (rst),
            .above (above_v[i]),
            .below (below_v[i]),
            .en    (en_v[i]),
            .clr   (clr),
            .flag  (flag_q[i]),
            .evt   (evt_q[i])
        );
    end

    always_comb begin
        ot_any = |(en_v & (mode_intr ? evt_q : flag_q));
    end

    ota_pin_mux u_mux (
        .ot_any      (ot_any),
        .pin_sel_smi (pin_sel_smi),
        .smi_n       (smi_n),
        .alert_n     (alert_n)
    );
endmodule

// File: rtl/ota_alert_chk.sv
module ota_alert_chk #(
    parameter int unsigned TW = 8,
    parameter int unsigned NS = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [TW-1:0] temp_sys,
    input logic [TW-1:0] temp_cpu,
    input logic [TW-1:0] lim_hi,
    input logic [TW-1:0] lim_hyst,
    input logic          mode_intr,
    input logic          en_sys,
    input logic          en_cpu,
    input logic          pin_sel_smi,
    input logic          smi_n,
    input logic          stat_rd,
    input logic          alert_n,
    input logic [NS-1:0] flag_q,
    input logic [NS-1:0] evt_q,
    input logic          mode_q
);
    logic [TW-1:0] tv [NS];
    always_comb begin
        tv[0] = temp_sys;
        tv[1] = temp_cpu;
    end

    p_pin_smi_r1: assert property (@(posedge clk) disable iff (rst)
        pin_sel_smi |-> (alert_n == smi_n));

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!pin_sel_smi && !en_sys && !en_cpu) |-> alert_n);

    for (genvar i = 0; i < NS; i++) begin : g_chk
        p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
            ($signed(tv[i]) > $signed(lim_hi)) |=> flag_q[i]);

        p_flag_clr_r5: assert property (@(posedge clk) disable iff (rst)
            (($signed(tv[i]) < $signed(lim_hyst)) && !($signed(tv[i]) > $signed(lim_hi)))
            |=> !flag_q[i]);

        p_evt_from_flag_r7: assert property (@(posedge clk) disable iff (rst)
            $rose(evt_q[i]) |-> (flag_q[i] != $past(flag_q[i])));

        p_evt_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (evt_q[i] && !stat_rd && (mode_intr == mode_q)) |=> evt_q[i]);

        p_rd_clear_r8: assert property (@(posedge clk) disable iff (rst)
            stat_rd |=> (!evt_q[i] || (flag_q[i] != $past(flag_q[i]))));

        p_mode_clear_r9: assert property (@(posedge clk) disable iff (rst)
            (mode_intr != mode_q) |=> (!evt_q[i] || (flag_q[i] != $past(flag_q[i]))));
    end
endmodule

bind ota_alert_gen ota_alert_chk #(.TW(TW), .NS(NS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .temp_sys    (temp_sys),
    .temp_cpu    (temp_cpu),
    .lim_hi      (lim_hi),
    .lim_hyst    (lim_hyst),
    .mode_intr   (mode_intr),
    .en_sys      (en_sys),
    .en_cpu      (en_cpu),
    .pin_sel_smi (pin_sel_smi),
    .smi_n       (smi_n),
    .stat_rd     (stat_rd),
    .alert_n     (alert_n),
    .flag_q      (flag_q),
    .evt_q       (evt_q),
    .mode_q      (mode_q)
);

// File: tb/ota_alert_gen_bench.sv
module ota_alert_gen_bench;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] temp_sys = '0, temp_cpu = '0, lim_hi = 8'd10, lim_hyst = 8'd5;
    logic          mode_intr = 1'b0, en_sys = 1'b1, en_cpu = 1'b1;
    logic          pin_sel_smi = 1'b0, smi_n = 1'b1, stat_rd = 1'b0;
    logic          alert_n;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // reference state
    logic mf [2];
    logic me [2];
    logic mmq;

    always #5 clk = ~clk;

    ota_alert_gen #(.TW(TW)) u_ota_alert_gen (
        .clk(clk), .rst(rst), .temp_sys(temp_sys), .temp_cpu(temp_cpu),
        .lim_hi(lim_hi), .lim_hyst(lim_hyst), .mode_intr(mode_intr),
        .en_sys(en_sys), .en_cpu(en_cpu), .pin_sel_smi(pin_sel_smi),
        .smi_n(smi_n), .stat_rd(stat_rd), .alert_n(alert_n)
    );

    function automatic logic expect_pin();
        logic ot;
        ot = (en_sys && (mode_intr ? me[0] : mf[0])) ||
             (en_cpu && (mode_intr ? me[1] : mf[1]));
        return pin_sel_smi ? smi_n : ~ot;
    endfunction

    task automatic check(input string tag);
        logic e;
        e = expect_pin();
        vectors++;
        if (alert_n !== e) begin
            errors++;
            $display("FAIL %s: alert_n=%b expected %b (ts=%0d tc=%0d mode=%b)",
                     tag, alert_n, e, $signed(temp_sys), $signed(temp_cpu), mode_intr);
        end
    endtask

    // Drive at negedge, advance one clock, check at next negedge.
    task automatic step(input int ts, input int tc, input logic rd, input string tag);
        logic nf [2];
        logic ne [2];
        logic clr;
        int   t [2];
        logic en [2];
        temp_sys = TW'(ts);
        temp_cpu = TW'(tc);
        stat_rd  = rd;
        t[0] = $signed(temp_sys); t[1] = $signed(temp_cpu);
        en[0] = en_sys; en[1] = en_cpu;
        clr = rd || (mode_intr != mmq);
        for (int i = 0; i < 2; i++) begin
            if (t[i] > $signed(lim_hi))        nf[i] = 1'b1;
            else if (t[i] < $signed(lim_hyst)) nf[i] = 1'b0;
            else                               nf[i] = mf[i];
            if (nf[i] != mf[i] && en[i]) ne[i] = 1'b1;
            else if (clr)                ne[i] = 1'b0;
            else                         ne[i] = me[i];
        end
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            mf[i] = nf[i];
            me[i] = ne[i];
        end
        mmq = mode_intr;
        @(negedge clk);
        stat_rd = 1'b0;
        check(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mf[0] = 0; mf[1] = 0; me[0] = 0; me[1] = 0; mmq = 0;
    endtask

    // Full sweep of one sensor, up then down; other sensor held at 0.
    task automatic sweep(input int which, input int rd_every, input string tag);
        int n = 0;
        for (int v = -128; v <= 127; v++) begin
            n++;
            step(which == 0 ? v : 0, which == 1 ? v : 0,
                 (rd_every > 0) && (n % rd_every == 0), tag);
        end
        for (int v = 127; v >= -128; v--) begin
            n++;
            step(which == 0 ? v : 0, which == 1 ? v : 0,
                 (rd_every > 0) && (n % rd_every == 0), tag);
        end
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        do_reset();
        check("R3 reset R10");

        // R4 R5 R6: comparator mode, all enable combinations
        for (int ec = 0; ec < 4; ec++) begin
            en_sys = ec[0];
            en_cpu = ec[1];
            sweep(0, 0, "R6 R4 R5 R2 comparator");
            sweep(1, 0, "R6 R4 R5 R2 comparator");
        end

        // negative thresholds
        lim_hi = 8'hFE; lim_hyst = 8'hF8; en_sys = 1; en_cpu = 1;
        sweep(0, 0, "R4 R5 negative limits");

        // extremes: flag can never change
        lim_hi = 8'd127; lim_hyst = 8'h80;
        sweep(1, 0, "R4 R5 extreme limits");

        // R7 R8: interrupt mode with reads at odd intervals
        lim_hi = 8'd10; lim_hyst = 8'd5;
        mode_intr = 1'b1;
        step(0, 0, 1'b0, "R9 mode switch");
        for (int ec = 0; ec < 4; ec++) begin
            en_sys = ec[0];
            en_cpu = ec[1];
            sweep(0, 37, "R7 R8 R2 interrupt");
            sweep(1, 53, "R7 R8 R2 interrupt");
        end
        en_sys = 1; en_cpu = 1;

        // R8: event in same cycle as read wins
        step(0, 0, 1'b1, "R8 clear");
        step(11, 0, 1'b1, "R8 event beats clear");
        step(11, 0, 1'b0, "R8 event held");
        step(12, 0, 1'b0, "R7 no refire");
        step(12, 0, 1'b1, "R8 read clears");
        step(4, 0, 1'b0, "R7 falling event");
        step(4, 0, 1'b0, "R8 held");

        // R9: mode change clears a pending event
        mode_intr = 1'b0;
        step(4, 0, 1'b0, "R9 to comparator");
        step(11, 0, 1'b0, "R6 flag on");
        mode_intr = 1'b1;
        step(11, 0, 1'b0, "R9 clear on switch");
        step(3, 0, 1'b0, "R7 event after switch");
        mode_intr = 1'b0;
        step(20, 0, 1'b0, "R9 event beats switch clear");
        mode_intr = 1'b1;
        step(20, 0, 1'b0, "R9 cleared");

        // R1: pin select
        pin_sel_smi = 1'b1;
        for (int k = 0; k < 8; k++) begin
            smi_n = k[0];
            step(k[1] ? 20 : 0, 0, 1'b0, "R1 smi routed");
        end
        pin_sel_smi = 1'b0;
        step(20, 0, 1'b0, "R1 alert routed");

        // R10: reset mid-run
        do_reset();
        check("R10 reset clears");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule